// File: doc/BRIEF.md
# System Clock-Enable Divider

This block derives four clock-enable strobes from one fast reference clock: one for the core, one for a high-speed bus, one for a low-speed bus and one for memory. Each domain is steered by a 4-bit code held in a single control register. The code picks a ratio from a fixed, non-uniform set. The domain's enable is then high for one reference cycle out of every "ratio" cycles. Logic downstream qualifies its flops with that enable instead of running on a separately divided clock.

Software writes the whole control register through a plain write strobe and reads it back on a combinational read bus. One bit of the register decides whether written codes may reach the dividers. While that bit is clear, new codes wait in the register and the dividers keep their present ratios. Once it is set, each divider picks up its new ratio at the end of its current period, so no strobe interval is ever cut short. A second bit gates an auxiliary strobe that mirrors the memory enable.

Top module: `sysclk_div_top`

## Requirements
- R1: After reset the control register reads 0. All four enables are high on every cycle, and `aux_en` is low.
- R2: Code values 0 to 9 select ratios 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 respectively. With ratio R applied, a domain's enable is high for exactly one cycle in every R cycles.
- R3: Any code from 10 to 15 selects ratio 32.
- R4: The register fields map to domains as follows: bits 3:0 core, bits 7:4 high-speed bus, bits 11:8 low-speed bus, bits 15:12 memory. Each domain divides independently of the others.
- R5: A domain whose applied ratio is 1 holds its enable high continuously.
- R6: `reg_rdata` returns the value last written, restricted to the implemented bits 15:0, 22 and 30. All other bits read 0. The new value is visible from the cycle after the write strobe.
- R7: While bit 22 (change-enable) is 0, newly written codes are stored and read back, but every domain keeps dividing by its previously applied ratio.
- R8: When bit 22 is 1, the stored codes are applied. Codes written earlier with bit 22 clear take effect once bit 22 is later set.
- R9: A new ratio is adopted only at the terminal count of the current period. The strobe interval that spans the change therefore equals the old ratio.
- R10: When bit 30 is 1, `aux_en` equals `mem_en` on every cycle. When bit 30 is 0, `aux_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data for the control register |
| reg_rdata | output | 32 | Current control register contents |
| core_en | output | 1 | Core clock-enable strobe |
| hbus_en | output | 1 | High-speed bus clock-enable strobe |
| lbus_en | output | 1 | Low-speed bus clock-enable strobe |
| mem_en | output | 1 | Memory clock-enable strobe |
| aux_en | output | 1 | Auxiliary strobe, a gated copy of the memory enable |

## Verification
Each kind of internal fault shows up at the ports within one divide period, so at most 32 cycles after the fault:
- A corrupted divider counter or applied ratio appears as one wrong interval between consecutive strobes.
- A wrong code-to-ratio decode gives a steady but incorrect interval.
- A field mapped to the wrong domain moves the wrong strobe.

The bench measures every interval between pulses against a queue of expected lengths. It also places a code change mid-period to catch a shortened interval. Register faults appear at once on the read bus.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned NUM_DOM  = 4;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned RAT_W    = 6;
  localparam int unsigned MAX_CODE = 9;
  localparam int unsigned CHG_BIT  = 22;
  localparam int unsigned AUX_BIT  = 30;

  typedef enum logic [1:0] {
    DOM_CORE = 2'd0,
    DOM_HBUS = 2'd1,
    DOM_LBUS = 2'd2,
    DOM_MEM  = 2'd3
  } dom_e;
endpackage

// File: rtl/clkdiv_ctl_reg.sv
module clkdiv_ctl_reg #(
  parameter int unsigned REG_W = 32,
  parameter logic [REG_W-1:0] WMASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  // Only implemented bits are stored; the rest stay zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata & WMASK;
  end
endmodule

// File: rtl/clkdiv_ratio_lut.sv
module clkdiv_ratio_lut #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned RAT_W    = 6,
  parameter int unsigned MAX_CODE = 9
) (
  input  logic [CODE_W-1:0] code,
  output logic [RAT_W-1:0]  ratio
);
  localparam logic [CODE_W-1:0] SAT = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0] c_sat;
  logic [CODE_W-1:0] sh;

  // Odd codes give a single set bit (2^k); even codes above zero give
  // two adjacent set bits (3 * 2^k). Out-of-range codes clamp to the top.
  always_comb begin
    c_sat = (code > SAT) ? SAT : code;
    sh    = '0;
    ratio = RAT_W'(1);
    if (c_sat != '0) begin
      if (c_sat[0]) begin
        sh    = (c_sat + CODE_W'(1)) >> 1;
        ratio = RAT_W'(1) << sh;
      end else begin
        sh    = (c_sat >> 1) - CODE_W'(1);
        ratio = RAT_W'(3) << sh;
      end
    end
  end
endmodule

// File: rtl/clkdiv_domain.sv
module clkdiv_domain #(
  parameter int unsigned RAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAT_W-1:0] next_ratio,
  input  logic             load_ok,
  output logic             en_o,
  output logic [RAT_W-1:0] ratio_o
);
  localparam int unsigned CNT_W = RAT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [RAT_W-1:0] ratio_q;
  logic             tc;

  assign tc      = ({1'b0, cnt_q} == (ratio_q - RAT_W'(1)));
  assign en_o    = tc;
  assign ratio_o = ratio_q;

  // Ratio is only replaced at the end of a full period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RAT_W'(1);
    end else if (tc) begin
      cnt_q <= '0;
      if (load_ok) ratio_q <= next_ratio;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sysclk_div_top.sv
module sysclk_div_top
  import clkdiv_pkg::*;
#(
  parameter int unsigned P_REG_W    = REG_W,
  parameter int unsigned P_CODE_W   = CODE_W,
  parameter int unsigned P_RAT_W    = RAT_W,
  parameter int unsigned P_MAX_CODE = MAX_CODE,
  parameter int unsigned P_CHG_BIT  = CHG_BIT,
  parameter int unsigned P_AUX_BIT  = AUX_BIT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [P_REG_W-1:0] reg_wdata,
  output logic [P_REG_W-1:0] reg_rdata,
  output logic               core_en,
  output logic               hbus_en,
  output logic               lbus_en,
  output logic               mem_en,
  output logic               aux_en
);
  localparam int unsigned FIELD_BITS = NUM_DOM * P_CODE_W;
  localparam logic [P_REG_W-1:0] WMASK =
      P_REG_W'({FIELD_BITS{1'b1}})
    | (P_REG_W'(1) << P_CHG_BIT)
    | (P_REG_W'(1) << P_AUX_BIT);

  logic [P_REG_W-1:0]                ctl_q;
  logic                              chg_on;
  logic                              aux_on;
  logic [NUM_DOM-1:0][P_RAT_W-1:0]   next_ratio;
  logic [NUM_DOM-1:0][P_RAT_W-1:0]   act_ratio;
  logic [NUM_DOM-1:0]                en_vec;

  clkdiv_ctl_reg #(.REG_W(P_REG_W), .WMASK(WMASK)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .q     (ctl_q)
  );

  assign chg_on    = ctl_q[P_CHG_BIT];
  assign aux_on    = ctl_q[P_AUX_BIT];
  assign reg_rdata = ctl_q;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    clkdiv_ratio_lut #(
      .CODE_W   (P_CODE_W),
      .RAT_W    (P_RAT_W),
      .MAX_CODE (P_MAX_CODE)
    ) u_lut (
      .code  (ctl_q[d*P_CODE_W +: P_CODE_W]),
      .ratio (next_ratio[d])
    );

    clkdiv_domain #(.RAT_W(P_RAT_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .next_ratio (next_ratio[d]),
      .load_ok    (chg_on),
      .en_o       (en_vec[d]),
      .ratio_o    (act_ratio[d])
    );
  end

  assign core_en = en_vec[DOM_CORE];
  assign hbus_en = en_vec[DOM_HBUS];
  assign lbus_en = en_vec[DOM_LBUS];
  assign mem_en  = en_vec[DOM_MEM];
  assign aux_en  = en_vec[DOM_MEM] & aux_on;
endmodule

// File: rtl/sysclk_div_chk.sv
module sysclk_div_chk #(
  parameter int unsigned NDOM  = 4,
  parameter int unsigned RW    = 6,
  parameter int unsigned MEM_I = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     chg_on,
  input logic                     aux_on,
  input logic [NDOM-1:0]          en_vec,
  input logic [NDOM-1:0][RW-1:0]  act_ratio,
  input logic                     aux_en
);
  for (genvar d = 0; d < NDOM; d++) begin : g_chk
    // R5
    a_r5_unity_high: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ratio[d] == RW'(1)) |-> en_vec[d]);
    // R2
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec[d] && act_ratio[d] > RW'(1) && !chg_on) |=> !en_vec[d]);
    // R9
    a_r9_switch_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[d] |=> $stable(act_ratio[d]));
    // R7
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_on |=> $stable(act_ratio[d]));
  end

  // R10
  a_r10_aux_follows: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |-> (en_vec[MEM_I] && aux_on));
  a_r10_aux_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_on && en_vec[MEM_I]) |-> aux_en);
endmodule

bind sysclk_div_top sysclk_div_chk #(
  .NDOM  (clkdiv_pkg::NUM_DOM),
  .RW    (P_RAT_W),
  .MEM_I (clkdiv_pkg::NUM_DOM - 1)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chg_on    (chg_on),
  .aux_on    (aux_on),
  .en_vec    (en_vec),
  .act_ratio (act_ratio),
  .aux_en    (aux_en)
);

// File: tb/sim_sysclk_div_top.sv
`timescale 1ns/1ps
module sim_sysclk_div_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_en, hbus_en, lbus_en, mem_en, aux_en;
  logic [3:0]  en;

  int n_chk = 0;
  int n_err = 0;

  int    exp_q [4][$];
  bit    started [4];
  int    since [4];
  string mon_tag [4];

  always #5 clk = ~clk;

  sysclk_div_top u0 (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .core_en (core_en), .hbus_en (hbus_en),
    .lbus_en (lbus_en), .mem_en (mem_en), .aux_en (aux_en)
  );

  assign en = {mem_en, lbus_en, hbus_en, core_en};

  function automatic int ratio_of(int code);
    int tbl [10] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32};
    return (code > 9) ? 32 : tbl[code];
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // Driver: queue expected strobe intervals for one domain.
  task automatic arm(int d, string tag, int ratio, int n);
    @(posedge clk); #1;
    started[d] = 1'b0;
    exp_q[d].delete();
    mon_tag[d] = tag;
    for (int i = 0; i < n; i++) exp_q[d].push_back(ratio);
  endtask

  task automatic drain(int d);
    int guard = 0;
    while (exp_q[d].size() > 0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    if (exp_q[d].size() > 0) chk({mon_tag[d], " drain"}, exp_q[d].size(), 0);
  endtask

  // Monitor: measure intervals between pulses and compare with the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 4; d++) begin
        since[d] = since[d] + 1;
        if (en[d]) begin
          if (started[d] && exp_q[d].size() > 0) begin
            int e;
            e = exp_q[d].pop_front();
            chk($sformatf("%s dom%0d interval", mon_tag[d], d), since[d], e);
          end
          since[d]   = 0;
          started[d] = 1'b1;
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int mism, cnt;
    for (int d = 0; d < 4; d++) begin since[d] = 0; started[d] = 1'b0; mon_tag[d] = "idle"; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R5: reset state
    chk("R1 rdata", reg_rdata, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 R5 all enables high", en, 4'hF);
      chk("R1 aux low", aux_en, 0);
    end

    // R4 / R2 / R6: distinct codes per field
    wr(32'h0040_9531);
    chk("R6 readback", reg_rdata, 32'h0040_9531);
    repeat (70) @(posedge clk);
    arm(0, "R4", 2, 3); arm(1, "R4", 4, 3); arm(2, "R4", 8, 3); arm(3, "R4", 32, 3);
    for (int d = 0; d < 4; d++) drain(d);

    // R3: codes above 9 clamp
    wr(32'h0040_42FA);
    repeat (70) @(posedge clk);
    arm(0, "R3", 32, 2); arm(1, "R3", 32, 2); arm(2, "R2", 3, 3); arm(3, "R2", 6, 3);
    for (int d = 0; d < 4; d++) drain(d);

    // R2 / R5: every table code on the core field
    for (int c = 0; c < 10; c++) begin
      wr(32'h0040_0000 | c);
      repeat (70) @(posedge clk);
      arm(0, (c == 0) ? "R5" : "R2", ratio_of(c), 3);
      drain(0);
    end

    // R7: codes held while change-enable is clear
    wr(32'h0000_0003);
    chk("R7 readback of held code", reg_rdata, 32'h0000_0003);
    repeat (70) @(posedge clk);
    arm(0, "R7", 32, 2);
    drain(0);

    // R8: setting change-enable applies the held code
    wr(32'h0040_0003);
    repeat (70) @(posedge clk);
    arm(0, "R8", 4, 3);
    drain(0);

    // R9: change mid-period keeps the old interval once
    wr(32'h0040_0009);
    repeat (70) @(posedge clk);
    @(posedge clk); #1;
    started[0] = 1'b0;
    exp_q[0].delete();
    mon_tag[0] = "R9";
    exp_q[0].push_back(32);
    exp_q[0].push_back(1);
    exp_q[0].push_back(1);
    exp_q[0].push_back(1);
    while (!started[0]) @(negedge clk);
    repeat (5) @(negedge clk);
    wr(32'h0040_0000);
    drain(0);

    // R10: auxiliary strobe gating
    wr(32'h4040_3000);
    chk("R6 readback aux", reg_rdata, 32'h4040_3000);
    repeat (70) @(posedge clk);
    mism = 0; cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (aux_en !== mem_en) mism++;
      if (mem_en) cnt++;
    end
    chk("R10 aux mirrors mem", mism, 0);
    chk("R10 mem pulses at ratio 4", cnt, 16);
    wr(32'h0040_3000);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (aux_en) cnt++;
    end
    chk("R10 aux off", cnt, 0);

    // R6: unimplemented bits read zero
    wr(32'hFFFF_FFFF);
    chk("R6 mask", reg_rdata, 32'h4040_FFFF);
    wr(32'h0000_0000);
    chk("R6 clear", reg_rdata, 0);

    finish_run();
  end
endmodule